// File: doc/BRIEF.md
# Bus Error Capture and Lock Registers

This block keeps a record of the first failure seen on an external bus interface and holds it until software collects it. Two independent capture groups exist. The bus-cycle group watches completed bus cycles for hard-error and soft-error acknowledge codes, and watches cache tag probes for parity faults in the tag address RAM and the tag control RAM. The fill group watches primary cache line fills for correction-code or parity faults.

When a group is empty, its first error loads the error flags and the context of the failing access. For the bus-cycle group the context is the bus command and the word address. For the fill group it is the cache that was being filled, the bad quadword and the line address. After that the group is frozen. A further serious error only raises that group's sticky overflow flag.

Software reads the registers through a single-cycle combinational read port. Reading a group's address register releases that group at the next clock edge. Tag probes are assumed to present their command and address on the same bus-cycle command and address inputs.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, or while reset is asserted, every read selection (0 status, 1 cycle address, 2 fill address, 3 unused) returns zero.
- R2: A cycle with `cyc_done_i` high sets a status bit according to its ack code. Code 2'b10 (hard) sets bit 0 and code 2'b01 (soft) sets bit 1. Codes 2'b00 and 2'b11 set nothing. A probe with `probe_i` high sets bit 2 for a tag address parity fault and bit 3 for a tag control parity fault. Events in the same cycle are captured together.
- R3: On the first bus-cycle error the bus command is loaded into status bits 7:4 and the word address into the cycle address register. While the group holds an error, later events leave status bits 3:0, status bits 7:4 and the address unchanged.
- R4: A hard error or either tag parity fault that arrives while the bus-cycle group holds an error sets status bit 8. A soft error in that state does not set it. Bit 8 and bit 14 clear only on reset.
- R5: Reading selection 1 returns captured address bits 33:5 in bits 33:5. Bits 4:2 carry the captured address bits only when the captured command is 4'h4 (block read) or 4'h5 (locked read), and read zero for any other command. Bits 63:34 and 1:0 are always zero.
- R6: Reading selection 1 clears status bits 7:0 and the cycle address at the next edge. A bus-cycle error in the same cycle as that read is captured as a new first error and does not set bit 8.
- R7: With `parity_mode_i` low, a fill correction-code fault sets status bit 9 and fill parity faults are ignored. With it high, a fill parity fault sets bit 10 and correction-code faults are ignored. A first fill error also loads bit 11 (1 for an instruction-cache fill, 0 for a data-cache fill), bits 13:12 (the quadword) and the fill line address.
- R8: While the fill group holds an error, an uncorrectable correction-code fault or a parity fault sets status bit 14. A correctable fault does not set it. The captured fill fields stay unchanged.
- R9: Reading selection 2 returns the fill line address in bits 33:5 and zeros elsewhere. It clears status bits 13:9 and the fill address at the next edge. A fill error in that same cycle is captured as a new first error.
- R10: With `rd_en_i` low, or with selection 3, the read data is zero. Reading the status register changes no state.
- R11: Releasing one group leaves the other group's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_done_i | input | 1 | A bus cycle completes this cycle |
| cyc_ack_i | input | 2 | Completion acknowledge code |
| cyc_cmd_i | input | 4 | Bus command of the current cycle or probe |
| cyc_addr_i | input | PA_W-2 | Word address (bits 33:2) of the current cycle or probe |
| probe_i | input | 1 | A cache tag probe is checked this cycle |
| probe_addr_perr_i | input | 1 | Parity fault in the tag address RAM |
| probe_ctl_perr_i | input | 1 | Parity fault in the tag control RAM |
| fill_valid_i | input | 1 | A fill quadword is checked this cycle |
| fill_icache_i | input | 1 | Fill is for the instruction cache |
| fill_qw_i | input | 2 | Quadword index within the 32-byte line |
| fill_addr_i | input | PA_W-LINE_LSB | Fill line address (bits 33:5) |
| fill_ecc_err_i | input | 1 | Correction-code fault on fill data |
| fill_ecc_fatal_i | input | 1 | That fault is uncorrectable |
| fill_par_err_i | input | 1 | Parity fault on fill data |
| parity_mode_i | input | 1 | 1: parity protection, 0: correction-code protection |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 2 | Read selection: 0 status, 1 cycle address, 2 fill address |
| rd_data_o | output | DATA_W | Read data, valid in the same cycle as the strobe |

## Verification
The bench targets a release read that coincides with a new error. A design that treats that error as overflow would set the fatal flag and leave the status empty. A soft error that arrives while the group is locked is also exercised: a design that flags every late error would set the fatal flag there. For the fill group, the bench checks that correctable faults do not cause overflow. It also checks that the fault type belonging to the other protection mode is ignored, because a design that skips the mode gating would log phantom errors. Address reads are taken after block-read, locked-read and other commands. A design that masks bits 4:2 wrongly returns a stale or zeroed word offset.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int CMD_W = 4;
  localparam int QW_W  = 2;
  localparam int NSRC  = 4;

  localparam int SRC_HARD    = 0;
  localparam int SRC_SOFT    = 1;
  localparam int SRC_TAG_ADR = 2;
  localparam int SRC_TAG_CTL = 3;

  typedef enum logic [1:0] {
    ACK_OK   = 2'b00,
    ACK_SOFT = 2'b01,
    ACK_HARD = 2'b10,
    ACK_RSVD = 2'b11
  } ack_e;

  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_CADDR = 2'd1,
    SEL_FADDR = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  localparam logic [CMD_W-1:0] CMD_RD_BLOCK = 4'h4;
  localparam logic [CMD_W-1:0] CMD_RD_LOCK  = 4'h5;

  localparam int ST_CMD_LSB  = 4;
  localparam int ST_FATAL1   = 8;
  localparam int ST_FECC     = 9;
  localparam int ST_FPAR     = 10;
  localparam int ST_FICACHE  = 11;
  localparam int ST_FQW_LSB  = 12;
  localparam int ST_FATAL2   = 14;

  function automatic logic keeps_subline(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_RD_BLOCK) || (cmd == CMD_RD_LOCK);
  endfunction
endpackage

// File: rtl/bec_cyc_log.sv
module bec_cyc_log
  import bec_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [PA_W-1:2]  addr_i,
  input  logic             unlock_i,
  output logic [NSRC-1:0]  err_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [PA_W-1:2]  addr_o,
  output logic             fatal_o
);
  logic             locked, open_win, capture, ovf;
  logic [CMD_W-1:0] cmd_q;
  logic [PA_W-1:2]  addr_q;
  logic             fatal_q;

  assign locked   = |err_o;
  assign open_win = !locked || unlock_i;
  assign capture  = open_win && (|src_i);
  // soft acks never count as overflow
  assign ovf      = !open_win &&
                    (src_i[SRC_HARD] || src_i[SRC_TAG_ADR] || src_i[SRC_TAG_CTL]);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (capture)  bit_q <= src_i[g];
      else if (unlock_i) bit_q <= 1'b0;
    end
    assign err_o[g] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (capture) begin
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
    end else if (unlock_i) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  fatal_q <= 1'b0;
    else if (ovf) fatal_q <= 1'b1;
  end

  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign fatal_o = fatal_q;

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_o) && !unlock_i |=> $stable(err_o) && $stable(cmd_o) && $stable(addr_o));

  p_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_o) && !unlock_i &&
    (src_i[SRC_HARD] || src_i[SRC_TAG_ADR] || src_i[SRC_TAG_CTL]) |=> fatal_o);

  p_soft_no_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fatal_o && (|err_o) && (src_i == NSRC'(1 << SRC_SOFT)) |=> !fatal_o);

  p_fatal_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);

  p_unlock_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i && (src_i == '0) |=> (err_o == '0) && (addr_o == '0));

  p_relock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i && (src_i != '0) |=> (err_o == $past(src_i)) && $stable(fatal_o));
endmodule

// File: rtl/bec_fill_log.sv
module bec_fill_log
  import bec_pkg::*;
#(
  parameter int PA_W     = 34,
  parameter int LINE_LSB = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ecc_ev_i,
  input  logic                   par_ev_i,
  input  logic                   severe_ev_i,
  input  logic                   icache_i,
  input  logic [QW_W-1:0]        qw_i,
  input  logic [PA_W-1:LINE_LSB] addr_i,
  input  logic                   unlock_i,
  output logic                   ecc_o,
  output logic                   par_o,
  output logic                   icache_o,
  output logic [QW_W-1:0]        qw_o,
  output logic [PA_W-1:LINE_LSB] addr_o,
  output logic                   fatal_o
);
  logic                   ecc_q, par_q, icache_q, fatal_q;
  logic [QW_W-1:0]        qw_q;
  logic [PA_W-1:LINE_LSB] addr_q;
  logic                   locked, open_win, any_ev, capture;

  assign locked   = ecc_q || par_q;
  assign open_win = !locked || unlock_i;
  assign any_ev   = ecc_ev_i || par_ev_i;
  assign capture  = open_win && any_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_q    <= 1'b0;
      par_q    <= 1'b0;
      icache_q <= 1'b0;
      qw_q     <= '0;
      addr_q   <= '0;
    end else if (capture) begin
      ecc_q    <= ecc_ev_i;
      par_q    <= par_ev_i;
      icache_q <= icache_i;
      qw_q     <= qw_i;
      addr_q   <= addr_i;
    end else if (unlock_i) begin
      ecc_q    <= 1'b0;
      par_q    <= 1'b0;
      icache_q <= 1'b0;
      qw_q     <= '0;
      addr_q   <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fatal_q <= 1'b0;
    else if (!open_win && severe_ev_i) fatal_q <= 1'b1;
  end

  assign ecc_o    = ecc_q;
  assign par_o    = par_q;
  assign icache_o = icache_q;
  assign qw_o     = qw_q;
  assign addr_o   = addr_q;
  assign fatal_o  = fatal_q;

  p_fill_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_o || par_o) && !unlock_i |=>
    $stable(ecc_o) && $stable(par_o) && $stable(icache_o) && $stable(qw_o) && $stable(addr_o));

  p_fill_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_o || par_o) && !unlock_i && severe_ev_i |=> fatal_o);

  p_corr_no_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fatal_o && !severe_ev_i |=> !fatal_o);

  p_fill_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i && !ecc_ev_i && !par_ev_i |=> !ecc_o && !par_o && (addr_o == '0));
endmodule

// File: rtl/bec_rd_mux.sv
module bec_rd_mux
  import bec_pkg::*;
#(
  parameter int PA_W     = 34,
  parameter int LINE_LSB = 5,
  parameter int DATA_W   = 64
) (
  input  logic                   rd_en_i,
  input  logic [1:0]             rd_sel_i,
  input  logic [NSRC-1:0]        c_err_i,
  input  logic [CMD_W-1:0]       c_cmd_i,
  input  logic [PA_W-1:2]        c_addr_i,
  input  logic                   c_fatal_i,
  input  logic                   f_ecc_i,
  input  logic                   f_par_i,
  input  logic                   f_icache_i,
  input  logic [QW_W-1:0]        f_qw_i,
  input  logic [PA_W-1:LINE_LSB] f_addr_i,
  input  logic                   f_fatal_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  logic [DATA_W-1:0] stat_w, caddr_w, faddr_w;

  always_comb begin
    stat_w                              = '0;
    stat_w[NSRC-1:0]                    = c_err_i;
    stat_w[ST_CMD_LSB +: CMD_W]         = c_cmd_i;
    stat_w[ST_FATAL1]                   = c_fatal_i;
    stat_w[ST_FECC]                     = f_ecc_i;
    stat_w[ST_FPAR]                     = f_par_i;
    stat_w[ST_FICACHE]                  = f_icache_i;
    stat_w[ST_FQW_LSB +: QW_W]          = f_qw_i;
    stat_w[ST_FATAL2]                   = f_fatal_i;
  end

  always_comb begin
    caddr_w                    = '0;
    caddr_w[PA_W-1:LINE_LSB]   = c_addr_i[PA_W-1:LINE_LSB];
    if (keeps_subline(c_cmd_i))
      caddr_w[LINE_LSB-1:2]    = c_addr_i[LINE_LSB-1:2];
  end

  always_comb begin
    faddr_w                  = '0;
    faddr_w[PA_W-1:LINE_LSB] = f_addr_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      case (rd_sel_i)
        SEL_STAT:  rd_data_o = stat_w;
        SEL_CADDR: rd_data_o = caddr_w;
        SEL_FADDR: rd_data_o = faddr_w;
        default:   rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int PA_W     = 34,
  parameter int LINE_LSB = 5,
  parameter int DATA_W   = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cyc_done_i,
  input  logic [1:0]             cyc_ack_i,
  input  logic [CMD_W-1:0]       cyc_cmd_i,
  input  logic [PA_W-1:2]        cyc_addr_i,
  input  logic                   probe_i,
  input  logic                   probe_addr_perr_i,
  input  logic                   probe_ctl_perr_i,
  input  logic                   fill_valid_i,
  input  logic                   fill_icache_i,
  input  logic [QW_W-1:0]        fill_qw_i,
  input  logic [PA_W-1:LINE_LSB] fill_addr_i,
  input  logic                   fill_ecc_err_i,
  input  logic                   fill_ecc_fatal_i,
  input  logic                   fill_par_err_i,
  input  logic                   parity_mode_i,
  input  logic                   rd_en_i,
  input  logic [1:0]             rd_sel_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  logic [NSRC-1:0]        src;
  logic                   c_unlock, f_unlock;
  logic [NSRC-1:0]        c_err;
  logic [CMD_W-1:0]       c_cmd;
  logic [PA_W-1:2]        c_addr;
  logic                   c_fatal;
  logic                   ecc_ev, par_ev, severe_ev;
  logic                   f_ecc, f_par, f_icache, f_fatal;
  logic [QW_W-1:0]        f_qw;
  logic [PA_W-1:LINE_LSB] f_addr;

  assign src[SRC_HARD]    = cyc_done_i && (cyc_ack_i == ACK_HARD);
  assign src[SRC_SOFT]    = cyc_done_i && (cyc_ack_i == ACK_SOFT);
  assign src[SRC_TAG_ADR] = probe_i && probe_addr_perr_i;
  assign src[SRC_TAG_CTL] = probe_i && probe_ctl_perr_i;

  assign c_unlock = rd_en_i && (rd_sel_i == SEL_CADDR);
  assign f_unlock = rd_en_i && (rd_sel_i == SEL_FADDR);

  // protection mode picks which fill fault kind is meaningful
  assign ecc_ev    = fill_valid_i && !parity_mode_i && fill_ecc_err_i;
  assign par_ev    = fill_valid_i &&  parity_mode_i && fill_par_err_i;
  assign severe_ev = par_ev || (ecc_ev && fill_ecc_fatal_i);

  bec_cyc_log #(.PA_W(PA_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src),
    .cmd_i    (cyc_cmd_i),
    .addr_i   (cyc_addr_i),
    .unlock_i (c_unlock),
    .err_o    (c_err),
    .cmd_o    (c_cmd),
    .addr_o   (c_addr),
    .fatal_o  (c_fatal)
  );

  bec_fill_log #(.PA_W(PA_W), .LINE_LSB(LINE_LSB)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ecc_ev_i    (ecc_ev),
    .par_ev_i    (par_ev),
    .severe_ev_i (severe_ev),
    .icache_i    (fill_icache_i),
    .qw_i        (fill_qw_i),
    .addr_i      (fill_addr_i),
    .unlock_i    (f_unlock),
    .ecc_o       (f_ecc),
    .par_o       (f_par),
    .icache_o    (f_icache),
    .qw_o        (f_qw),
    .addr_o      (f_addr),
    .fatal_o     (f_fatal)
  );

  bec_rd_mux #(.PA_W(PA_W), .LINE_LSB(LINE_LSB), .DATA_W(DATA_W)) u_rd (
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .c_err_i    (c_err),
    .c_cmd_i    (c_cmd),
    .c_addr_i   (c_addr),
    .c_fatal_i  (c_fatal),
    .f_ecc_i    (f_ecc),
    .f_par_i    (f_par),
    .f_icache_i (f_icache),
    .f_qw_i     (f_qw),
    .f_addr_i   (f_addr),
    .f_fatal_i  (f_fatal),
    .rd_data_o  (rd_data_o)
  );

  p_par_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !parity_mode_i && !f_par |=> !f_par);

  p_ecc_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_mode_i && !f_ecc |=> !f_ecc);

  p_addr_pad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_sel_i == SEL_CADDR) |->
    (rd_data_o[1:0] == '0) && (rd_data_o[DATA_W-1:PA_W] == '0));

  p_addr_sub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_sel_i == SEL_CADDR) && !keeps_subline(c_cmd) |->
    (rd_data_o[LINE_LSB-1:2] == '0));

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));

  p_stat_read_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_sel_i == SEL_STAT) && (src == '0) && !ecc_ev && !par_ev |=>
    $stable(c_err) && $stable(c_addr) && $stable(f_ecc) && $stable(f_par) && $stable(f_addr));

  p_group_indep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_unlock && (src == '0) |=> $stable(c_err) && $stable(c_cmd) && $stable(c_addr));
endmodule

// File: tb/bus_err_capture_tb_top.sv
`timescale 1ns/1ps
module bus_err_capture_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        i_done, i_probe, i_tpa, i_tpc;
  logic [1:0]  i_ack;
  logic [3:0]  i_cmd;
  logic [33:2] i_addr;
  logic        i_fv, i_fic, i_fecc, i_func, i_fpar, i_pm;
  logic [1:0]  i_fqw;
  logic [33:5] i_faddr;
  logic        i_rd_en;
  logic [1:0]  i_rd_sel;
  logic [63:0] rd_data_o;

  bus_err_capture dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cyc_done_i(i_done), .cyc_ack_i(i_ack), .cyc_cmd_i(i_cmd), .cyc_addr_i(i_addr),
    .probe_i(i_probe), .probe_addr_perr_i(i_tpa), .probe_ctl_perr_i(i_tpc),
    .fill_valid_i(i_fv), .fill_icache_i(i_fic), .fill_qw_i(i_fqw), .fill_addr_i(i_faddr),
    .fill_ecc_err_i(i_fecc), .fill_ecc_fatal_i(i_func), .fill_par_err_i(i_fpar),
    .parity_mode_i(i_pm), .rd_en_i(i_rd_en), .rd_sel_i(i_rd_sel), .rd_data_o(rd_data_o)
  );

  // reference state
  logic [3:0]  m_err, m_cmd;
  logic [33:2] m_addr;
  logic        m_f1, m_fe, m_fp, m_fi, m_f2;
  logic [1:0]  m_fq;
  logic [33:5] m_fa;
  int n_chk = 0;
  int n_fail = 0;

  task automatic model_reset();
    m_err = '0; m_cmd = '0; m_addr = '0; m_f1 = 0;
    m_fe = 0; m_fp = 0; m_fi = 0; m_fq = '0; m_fa = '0; m_f2 = 0;
  endtask

  function automatic logic [63:0] model_read();
    logic [63:0] v = '0;
    if (!i_rd_en) return v;
    case (i_rd_sel)
      2'd0: v[14:0] = {m_f2, m_fq, m_fi, m_fp, m_fe, m_f1, m_cmd, m_err};
      2'd1: begin
        v[33:5] = m_addr[33:5];
        if (m_cmd == 4'h4 || m_cmd == 4'h5) v[4:2] = m_addr[4:2];
      end
      2'd2: v[33:5] = m_fa;
      default: ;
    endcase
    return v;
  endfunction

  task automatic model_step();
    logic [3:0] ev;
    bit rel_c, rel_f, held_c, held_f, fe, fp, sev;
    ev     = {i_probe & i_tpc, i_probe & i_tpa, i_done & (i_ack == 2'b01), i_done & (i_ack == 2'b10)};
    rel_c  = i_rd_en && i_rd_sel == 2'd1;
    rel_f  = i_rd_en && i_rd_sel == 2'd2;
    held_c = (m_err != 0) && !rel_c;
    held_f = (m_fe || m_fp) && !rel_f;
    if (rel_c) begin m_err = 0; m_cmd = 0; m_addr = 0; end
    if (ev != 0) begin
      if (!held_c) begin m_err = ev; m_cmd = i_cmd; m_addr = i_addr; end
      else if (ev[0] || ev[2] || ev[3]) m_f1 = 1;
    end
    fe  = i_fv && !i_pm && i_fecc;
    fp  = i_fv && i_pm && i_fpar;
    sev = fp || (fe && i_func);
    if (rel_f) begin m_fe = 0; m_fp = 0; m_fi = 0; m_fq = 0; m_fa = 0; end
    if (fe || fp) begin
      if (!held_f) begin m_fe = fe; m_fp = fp; m_fi = i_fic; m_fq = i_fqw; m_fa = i_faddr; end
      else if (sev) m_f2 = 1;
    end
  endtask

  task automatic idle();
    i_done = 0; i_ack = 0; i_cmd = 0; i_addr = '0; i_probe = 0; i_tpa = 0; i_tpc = 0;
    i_fv = 0; i_fic = 0; i_fqw = 0; i_faddr = '0; i_fecc = 0; i_func = 0; i_fpar = 0;
    i_rd_en = 0; i_rd_sel = 0;
  endtask

  task automatic tick(input string tag);
    logic [63:0] exp;
    #1;
    exp = model_read();
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data_o=%h expected %h", tag, rd_data_o, exp);
    end
    @(posedge clk_i);
    if (rst_ni) model_step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic set_cyc(input logic [1:0] ack, input logic [3:0] cmd, input logic [31:0] a);
    i_done = 1; i_ack = ack; i_cmd = cmd; i_addr = a;
  endtask
  task automatic set_probe(input bit pa, input bit pc, input logic [3:0] cmd, input logic [31:0] a);
    i_probe = 1; i_tpa = pa; i_tpc = pc; i_cmd = cmd; i_addr = a;
  endtask
  task automatic set_fill(input bit ecc, input bit unc, input bit par, input bit ic,
                          input logic [1:0] qw, input logic [28:0] a);
    i_fv = 1; i_fecc = ecc; i_func = unc; i_fpar = par; i_fic = ic; i_fqw = qw; i_faddr = a;
  endtask
  task automatic rd(input logic [1:0] sel);
    i_rd_en = 1; i_rd_sel = sel;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    idle(); i_pm = 0; model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1
    for (int s = 0; s < 4; s++) begin rd(s[1:0]); tick("R1 reset value"); end
    // R2
    set_cyc(2'b00, 4'h1, 32'h0000_1234); tick("R2 ok ack");
    set_cyc(2'b11, 4'h1, 32'h0000_1234); tick("R2 reserved ack");
    rd(0); tick("R2 nothing logged");
    set_cyc(2'b01, 4'h2, 32'hABCD_1237); tick("R2 soft ack");
    rd(0); tick("R2 R3 soft bit and command");
    rd(1); tick("R5 sub-line bits zero for other command");
    rd(0); tick("R6 status released");
    rd(1); tick("R6 address cleared");
    // R3 R4
    set_cyc(2'b10, 4'h4, 32'hFFFF_FFFF); tick("R2 hard ack");
    set_cyc(2'b01, 4'h7, 32'h1111_1111); tick("R4 soft while locked");
    rd(0); tick("R4 no overflow on soft");
    set_probe(1, 0, 4'h9, 32'h2222_2222); tick("R4 tag parity while locked");
    rd(0); tick("R3 R4 frozen with overflow");
    // R6 release read together with new error
    set_probe(0, 1, 4'h5, 32'h0F0F_0F0B); rd(1); tick("R5 block-read sub-line kept");
    rd(0); tick("R6 new first error after release");
    rd(1); tick("R5 locked-read sub-line kept");
    rd(0); tick("R4 overflow sticky after release");
    set_cyc(2'b10, 4'h3, 32'h5555_AAAA); set_probe(1, 0, 4'h3, 32'h5555_AAAA); tick("R2 joint events");
    rd(0); tick("R2 both bits captured");
    // R7 R8 correction-code mode
    i_pm = 0;
    set_fill(0, 0, 1, 1, 2'd1, 29'h0ABC_DEF); tick("R7 parity ignored in code mode");
    rd(0); tick("R7 no fill log");
    set_fill(1, 0, 0, 1, 2'd2, 29'h1234_567); tick("R7 code fault");
    rd(0); tick("R7 code fault logged");
    set_fill(1, 0, 0, 0, 2'd3, 29'h0000_111); tick("R8 correctable while locked");
    set_fill(0, 0, 1, 0, 2'd0, 29'h0000_222); tick("R8 parity ignored while locked");
    rd(0); tick("R8 no overflow yet");
    set_fill(1, 1, 0, 0, 2'd0, 29'h0000_333); tick("R8 uncorrectable while locked");
    rd(0); tick("R8 overflow, fields frozen");
    // R9 R11
    set_cyc(2'b10, 4'h6, 32'h7777_0001); tick("R11 cycle error");
    rd(2); tick("R9 fill address");
    rd(0); tick("R9 R11 fill cleared, cycle kept");
    // R7 parity mode
    i_pm = 1;
    set_fill(1, 1, 0, 1, 2'd1, 29'h0FFF_000); tick("R7 code fault ignored in parity mode");
    rd(0); tick("R7 no log");
    set_fill(0, 0, 1, 0, 2'd3, 29'h1F0F_0F0); tick("R7 parity fault");
    rd(0); tick("R7 parity logged, data cache");
    set_fill(0, 0, 1, 1, 2'd1, 29'h0101_010); rd(2); tick("R9 release with new fill");
    rd(0); tick("R9 new fill captured");
    // R10
    rd(0); tick("R10 status read once");
    rd(0); tick("R10 status read keeps state");
    rd(3); tick("R10 unused selection");
    i_rd_sel = 2'd1; i_rd_en = 0; tick("R10 strobe low");
    rd(1); tick("R10 R11 cycle address still held");
    rd(0); tick("R11 fill untouched by cycle release");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      i_done  = ($urandom_range(3) == 0);
      i_ack   = 2'($urandom);
      i_cmd   = 4'($urandom);
      i_addr  = $urandom;
      i_probe = ($urandom_range(7) == 0);
      i_tpa   = 1'($urandom);
      i_tpc   = 1'($urandom);
      i_fv    = ($urandom_range(3) == 0);
      i_fecc  = 1'($urandom);
      i_func  = 1'($urandom);
      i_fpar  = 1'($urandom);
      i_fic   = 1'($urandom);
      i_fqw   = 2'($urandom);
      i_faddr = 29'($urandom);
      i_rd_en = ($urandom_range(2) == 0);
      i_rd_sel = 2'($urandom);
      if (k % 50 == 0) i_pm = ~i_pm;
      tick("mixed traffic model compare");
    end
    // R1 reset mid-run
    rst_ni = 0; model_reset();
    rd(0); tick("R1 status in reset");
    rd(1); tick("R1 address in reset");
    rst_ni = 1;
    rd(0); tick("R1 status after reset");
    rd(2); tick("R1 fill address after reset");
    finish_run();
  end
endmodule